// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. The program counter, the register file and the data memory change state only on the rising clock edge. Everything between two edges is combinational. It runs a minimal load/store instruction set: word load and store, four register-to-register arithmetic and logic operations, a signed set-on-less-than, a compare-and-branch on equality and an absolute jump.

Instruction storage and data storage are word arrays inside the block. Each has a preload port that the surrounding environment uses while the core is held in reset. Two combinational peek ports expose one register and one data word, so the architectural state can be observed. Reset is asynchronous and active-low. Its release is synchronised, so the core starts fetching at address 0 two clock edges after `rst_n` rises.

Instruction fields: opcode in bits 31-26, rs in 25-21, rt in 20-16, rd in 15-11, 16-bit immediate in 15-0, funct in 5-0, jump index in 25-0.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0. After release, `pc_o` stays 0 through the second rising edge and reads 4 after the third.
- R2: An instruction that is neither a taken branch nor a jump advances the PC by exactly 4.
- R3: Opcode 0 with funct 32, 34, 36 or 37 writes rs+rt, rs-rt, rs AND rt or rs OR rt into register rd.
- R4: Opcode 0 with funct 42 writes 1 into rd when rs is less than rt as a signed 32-bit number, and 0 otherwise.
- R5: Opcode 35 loads the data word at address rs + sign-extended imm into register rt.
- R6: Opcode 43 writes register rt to the data word at address rs + sign-extended imm and changes no register, including the register named by bits 15-11.
- R7: Opcode 4 branches to PC+4 + (sign-extended imm << 2) when rs equals rt, and falls through to PC+4 otherwise. Negative offsets branch backward.
- R8: Opcode 2 jumps to {PC+4[31:28], instr[25:0], 2'b00}.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any opcode other than 0, 2, 4, 35 and 43, and opcode 0 with any funct other than the five listed, changes neither registers nor data memory and only advances the PC by 4.
- R11: Load and store offsets are sign-extended, so a negative immediate addresses below the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_ld_en | input | 1 | Instruction memory preload write enable |
| imem_ld_addr | input | IMEM_AW | Instruction word index for preload |
| imem_ld_data | input | 32 | Instruction word to preload |
| dmem_ld_en | input | 1 | Data memory preload write enable (wins over a store) |
| dmem_ld_addr | input | DMEM_AW | Data word index for preload |
| dmem_ld_data | input | 32 | Data word to preload |
| pc_o | output | 32 | Current program counter |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Value of the observed register |
| peek_mem_addr | input | DMEM_AW | Data word index to observe |
| peek_mem_data | output | 32 | Value of the observed data word |

## Verification
The arithmetic program loads a small positive, a negative and a second positive operand, then runs every funct code on them. Sum, difference, AND and OR differ for each pair, so a swapped funct decode shows up. The two set-on-less-than cases mix signs, which separates a signed compare from an unsigned one. The branch program places a not-taken compare, a taken forward branch, a jump over filler loads and a backward self-branch in sequence. Each skipped load would overwrite a marker register, so a wrong PC source is visible in the register values. A NOP-filled program checks the PC release timing and the plain +4 stepping. Stores with a negative offset, an unsupported opcode and an unknown funct are placed so that a stray register or memory write would change a seeded value.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_sel_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    reg_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0, reg_write: 1'b0,
            mem_write: 1'b0, branch: 1'b0, jump: 1'b0, alu_op: AOP_ADD};
    case (opcode)
      OPC_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_op    = AOP_FUNCT;
      end
      OPC_LOAD: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_write   = 1'b1;
      end
      OPC_STORE: begin
        ctl.b_is_imm  = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_SUB;
      end
      OPC_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  alu_op_e    alu_op,
  input  logic [5:0] funct,
  output alu_sel_e   sel,
  output logic       sel_ok
);
  always_comb begin
    sel    = ALU_ADD;
    sel_ok = 1'b1;
    case (alu_op)
      AOP_ADD: sel = ALU_ADD;
      AOP_SUB: sel = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  sel = ALU_ADD;
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_SLT:  sel = ALU_SLT;
          default: sel_ok = 1'b0;
        endcase
      end
      default: sel_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_sel_e       sel,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           zero
);
  always_comb begin
    case (sel)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [W-1:0]  rb_data,
  input  logic [AW-1:0] rc_idx,
  output logic [W-1:0]  rc_data,
  input  logic          we,
  input  logic [AW-1:0] wa_idx,
  input  logic [W-1:0]  wa_data
);
  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && (wa_idx != '0)) begin
      regs[wa_idx] <= wa_data;
    end
  end

  assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
  assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];
  assign rc_data = (rc_idx == '0) ? '0 : regs[rc_idx];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               imem_ld_en,
  input  logic [IMEM_AW-1:0] imem_ld_addr,
  input  logic [31:0]        imem_ld_data,
  input  logic               dmem_ld_en,
  input  logic [DMEM_AW-1:0] dmem_ld_addr,
  input  logic [31:0]        dmem_ld_data,
  output logic [31:0]        pc_o,
  input  logic [4:0]         peek_reg,
  output logic [31:0]        peek_reg_data,
  input  logic [DMEM_AW-1:0] peek_mem_addr,
  output logic [31:0]        peek_mem_data
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  // reset release synchroniser
  logic [1:0] rst_sync;
  logic       run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign run = rst_sync[1];

  // program counter
  logic [31:0] pc, pc_nxt, pc_plus4, br_target, jmp_target;
  logic        take_br, do_jmp;

  // storage
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  // decode
  logic [31:0] instr;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs_idx, rt_idx, rd_idx, wr_idx;
  logic [31:0] imm_sx;
  ctrl_t       ctl;
  alu_sel_e    alu_sel;
  logic        alu_ok;

  // execute / writeback
  logic [31:0] rs_data, rt_data, alu_b, alu_y, wb_data, dmem_rdata;
  logic        alu_zero, rf_we, dmem_we;
  logic [DMEM_AW-1:0] dmem_idx;

  assign instr  = imem[pc[IMEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign funct  = instr[5:0];
  assign imm_sx = {{16{instr[15]}}, instr[15:0]};

  sc_main_ctrl u_main_ctrl (
    .opcode (opcode),
    .ctl    (ctl)
  );

  sc_alu_ctrl u_alu_ctrl (
    .alu_op (ctl.alu_op),
    .funct  (funct),
    .sel    (alu_sel),
    .sel_ok (alu_ok)
  );

  assign wr_idx  = ctl.dst_is_rd ? rd_idx : rt_idx;
  assign rf_we   = run & ctl.reg_write & alu_ok;
  assign dmem_we = run & ctl.mem_write;

  sc_regfile #(.W(32), .NREGS(32)) u_regfile (
    .clk     (clk),
    .ra_idx  (rs_idx),
    .ra_data (rs_data),
    .rb_idx  (rt_idx),
    .rb_data (rt_data),
    .rc_idx  (peek_reg),
    .rc_data (peek_reg_data),
    .we      (rf_we),
    .wa_idx  (wr_idx),
    .wa_data (wb_data)
  );

  assign alu_b = ctl.b_is_imm ? imm_sx : rt_data;

  sc_alu #(.W(32)) u_alu (
    .sel  (alu_sel),
    .a    (rs_data),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign dmem_idx   = alu_y[DMEM_AW+1:2];
  assign dmem_rdata = dmem[dmem_idx];
  assign wb_data    = ctl.wb_from_mem ? dmem_rdata : alu_y;

  // three independent adders / target formers
  assign pc_plus4   = pc + 32'd4;
  assign br_target  = pc_plus4 + {imm_sx[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br    = ctl.branch & alu_zero;
  assign do_jmp     = ctl.jump;

  always_comb begin
    pc_nxt = pc_plus4;
    if (do_jmp)       pc_nxt = jmp_target;
    else if (take_br) pc_nxt = br_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc <= '0;
    else if (run) pc <= pc_nxt;
  end

  always_ff @(posedge clk) begin
    if (imem_ld_en) imem[imem_ld_addr] <= imem_ld_data;
  end

  always_ff @(posedge clk) begin
    if (dmem_ld_en)   dmem[dmem_ld_addr] <= dmem_ld_data;
    else if (dmem_we) dmem[dmem_idx]     <= rt_data;
  end

  assign pc_o          = pc;
  assign peek_mem_data = dmem[peek_mem_addr];

  logic unused_bits;
  assign unused_bits = ^{pc[31:IMEM_AW+2], pc[1:0], alu_y[31:DMEM_AW+2], alu_y[1:0], instr[10:6]};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] pc,
  input logic [31:0] pc_plus4,
  input logic [31:0] instr,
  input logic        take_br,
  input logic        do_jmp,
  input logic        rf_we,
  input logic        dmem_we,
  input logic [2:0]  alu_sel,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_data
);
  logic [5:0] opc;
  assign opc = instr[31:26];

  // R1
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pc == 32'd0);

  // R2
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !take_br && !do_jmp) |=> pc == $past(pc) + 32'd4);

  // R5, R6: load and store add the offset
  p_ls_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'd35 || opc == 6'd43) |-> alu_sel == 3'b010);

  // R6
  p_store_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'd43) |-> !rf_we);

  // R7
  p_beq_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'd4) |-> alu_sel == 3'b110);

  // R8
  p_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && do_jmp) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}) &&
                        (pc[31:28] == $past(pc_plus4[31:28])));

  // R9
  p_r0_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == 5'd0) |-> rs_data == 32'd0);

  // R10
  p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(opc inside {6'd0, 6'd2, 6'd4, 6'd35, 6'd43}) |-> (!rf_we && !dmem_we && !take_br && !do_jmp));
endmodule

bind sc_core sc_core_chk u_sc_core_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .pc       (pc),
  .pc_plus4 (pc_plus4),
  .instr    (instr),
  .take_br  (take_br),
  .do_jmp   (do_jmp),
  .rf_we    (rf_we),
  .dmem_we  (dmem_we),
  .alu_sel  (alu_sel),
  .rs_idx   (rs_idx),
  .rs_data  (rs_data)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam logic [31:0] NOP = 32'hFC00_0000;

  logic           clk;
  logic           rst_n;
  logic           imem_ld_en;
  logic [IAW-1:0] imem_ld_addr;
  logic [31:0]    imem_ld_data;
  logic           dmem_ld_en;
  logic [DAW-1:0] dmem_ld_addr;
  logic [31:0]    dmem_ld_data;
  logic [31:0]    pc_o;
  logic [4:0]     peek_reg;
  logic [31:0]    peek_reg_data;
  logic [DAW-1:0] peek_mem_addr;
  logic [31:0]    peek_mem_data;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  sc_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u_sc_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .imem_ld_en    (imem_ld_en),
    .imem_ld_addr  (imem_ld_addr),
    .imem_ld_data  (imem_ld_data),
    .dmem_ld_en    (dmem_ld_en),
    .dmem_ld_addr  (dmem_ld_addr),
    .dmem_ld_data  (dmem_ld_data),
    .pc_o          (pc_o),
    .peek_reg      (peek_reg),
    .peek_reg_data (peek_reg_data),
    .peek_mem_addr (peek_mem_addr),
    .peek_mem_data (peek_mem_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <=20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'd2, word[25:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fails = n_fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_i(int idx, logic [31:0] w);
    @(negedge clk);
    imem_ld_en = 1'b1; imem_ld_addr = idx[IAW-1:0]; imem_ld_data = w;
    @(negedge clk);
    imem_ld_en = 1'b0;
  endtask

  task automatic put_d(int idx, logic [31:0] w);
    @(negedge clk);
    dmem_ld_en = 1'b1; dmem_ld_addr = idx[DAW-1:0]; dmem_ld_data = w;
    @(negedge clk);
    dmem_ld_en = 1'b0;
  endtask

  task automatic hold_and_clear();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < (1 << IAW); i++) put_i(i, NOP);
  endtask

  task automatic release_and_run(int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_is(string req, int r, logic [31:0] exp);
    peek_reg = r[4:0];
    #1;
    check(req, peek_reg_data, exp);
  endtask

  task automatic mem_is(string req, int a, logic [31:0] exp);
    peek_mem_addr = a[DAW-1:0];
    #1;
    check(req, peek_mem_data, exp);
  endtask

  // R1, R2, R10: release timing and plain stepping over unsupported opcodes
  task automatic t_reset_and_step();
    logic [31:0] prev;
    hold_and_clear();
    put_d(0, 32'h1234_5678);
    #1;
    check("R1 pc in reset", pc_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pc after edge 1", pc_o, 32'd0);
    @(negedge clk);
    check("R1 pc after edge 2", pc_o, 32'd0);
    @(negedge clk);
    check("R1 pc after edge 3", pc_o, 32'd4);
    prev = pc_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 pc step", pc_o, prev + 32'd4);
      prev = pc_o;
    end
    mem_is("R10 nop leaves data", 0, 32'h1234_5678);
  endtask

  // R3..R6, R9..R11
  task automatic t_alu_and_mem();
    hold_and_clear();
    put_d(0, 32'd5);
    put_d(1, 32'hFFFF_FFFD);
    put_d(2, 32'd12);
    put_d(3, 32'd0);
    put_i(0,  enc_i(6'd35, 0, 1, 16'd0));
    put_i(1,  enc_i(6'd35, 0, 2, 16'd4));
    put_i(2,  enc_i(6'd35, 0, 3, 16'd8));
    put_i(3,  enc_i(6'd35, 0, 31, 16'd0));
    put_i(4,  enc_r(1, 3, 4, 6'd32));
    put_i(5,  enc_r(1, 3, 5, 6'd34));
    put_i(6,  enc_r(1, 3, 6, 6'd36));
    put_i(7,  enc_r(1, 3, 7, 6'd37));
    put_i(8,  enc_r(2, 1, 8, 6'd42));
    put_i(9,  enc_r(1, 2, 9, 6'd42));
    put_i(10, enc_r(1, 1, 0, 6'd32));
    put_i(11, enc_i(6'd63, 3, 1, 16'h1234));
    put_i(12, enc_r(1, 3, 1, 6'h3F));
    put_i(13, enc_i(6'd43, 0, 4, 16'd12));
    put_i(14, enc_i(6'd43, 3, 5, 16'hFFFC));
    put_i(15, enc_i(6'd35, 3, 10, 16'hFFF8));
    put_i(16, enc_j(16));
    release_and_run(30);
    reg_is("R5 load", 1, 32'd5);
    reg_is("R5 load neg", 2, 32'hFFFF_FFFD);
    reg_is("R3 add", 4, 32'd17);
    reg_is("R3 sub", 5, 32'hFFFF_FFF9);
    reg_is("R3 and", 6, 32'd4);
    reg_is("R3 or", 7, 32'd13);
    reg_is("R4 slt neg<pos", 8, 32'd1);
    reg_is("R4 slt pos<neg", 9, 32'd0);
    reg_is("R9 r0 zero", 0, 32'd0);
    reg_is("R6 store no regwrite", 31, 32'd5);
    reg_is("R11 load neg offset", 10, 32'hFFFF_FFFD);
    mem_is("R6 store", 3, 32'd17);
    mem_is("R11 store neg offset", 2, 32'hFFFF_FFF9);
    check("R8 self jump pc", pc_o, 32'd64);
  endtask

  // R7, R8
  task automatic t_branch_jump();
    hold_and_clear();
    put_d(0, 32'd7);
    put_d(1, 32'd7);
    put_d(2, 32'd9);
    put_d(3, 32'd1);
    put_i(0,  enc_i(6'd35, 0, 1, 16'd0));
    put_i(1,  enc_i(6'd35, 0, 2, 16'd4));
    put_i(2,  enc_i(6'd35, 0, 3, 16'd8));
    put_i(3,  enc_i(6'd35, 0, 5, 16'd12));
    put_i(4,  enc_i(6'd35, 0, 6, 16'd12));
    put_i(5,  enc_i(6'd4, 1, 3, 16'd1));
    put_i(6,  enc_i(6'd35, 0, 4, 16'd0));
    put_i(7,  enc_i(6'd4, 1, 2, 16'd2));
    put_i(8,  enc_i(6'd35, 0, 5, 16'd0));
    put_i(9,  enc_i(6'd35, 0, 5, 16'd0));
    put_i(10, enc_j(13));
    put_i(11, enc_i(6'd35, 0, 6, 16'd0));
    put_i(12, enc_i(6'd35, 0, 6, 16'd0));
    put_i(13, enc_i(6'd35, 0, 7, 16'd8));
    put_i(14, enc_i(6'd4, 0, 0, 16'hFFFF));
    release_and_run(30);
    reg_is("R7 not taken falls through", 4, 32'd7);
    reg_is("R7 taken skips", 5, 32'd1);
    reg_is("R8 jump skips", 6, 32'd1);
    reg_is("R8 jump lands", 7, 32'd9);
    check("R7 backward branch loop", pc_o, 32'd56);
    @(negedge clk);
    check("R7 loop holds", pc_o, 32'd56);
  endtask

  initial begin
    rst_n = 1'b0;
    imem_ld_en = 1'b0; imem_ld_addr = '0; imem_ld_data = '0;
    dmem_ld_en = 1'b0; dmem_ld_addr = '0; dmem_ld_data = '0;
    peek_reg = '0; peek_mem_addr = '0;
    repeat (3) @(negedge clk);
    t_reset_and_step();
    t_alu_and_mem();
    t_branch_jump();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule